// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is a bus master that turns a single transfer request into a complete bus cycle on a 16-bit multiplexed address/data bus with a 20-bit address. The cycle runs through five kinds of clock states: T1, T2, T3, zero or more wait states (TW), and T4. The same sixteen lines carry the address in T1 and the data afterwards. The four upper address lines carry status once the address phase is over. Every pin is modelled as a value plus an output enable, so that a pad ring or a testbench can build the tristate behaviour from the pair.

A client presents a request with `req_valid`. The request gives the direction, the memory or I/O space, the address, the write data, the high-byte wish, a two-bit segment code and the interrupt-enable flag to report. The request is taken in the cycle `req_take` is high, which can happen in IDLE or in T4, so cycles can run back to back. The cycle ends with a one-cycle `done` in T4. For reads, `rdata` then holds the word captured from the bus. A slave stretches the cycle by holding `rdy` low. An external master asks for the bus with `hold_req`. The sequencer grants it only between cycles and floats every bus and control pin while it holds.

States: S_IDLE (no cycle), S_T1 (address phase), S_T2 (turnaround / write data), S_T3 (data phase), S_TW (wait), S_T4 (completion), S_HOLD (bus granted away). Transitions: IDLE→HOLD on hold, IDLE→T1 on request, T1→T2, T2→T3, T3→T4 when ready else T3→TW, TW→TW while not ready, TW→T4 when ready, T4→HOLD on hold, T4→T1 on a new request, T4→IDLE otherwise, HOLD→IDLE when the hold drops.

Top module: `bseq_top`

## Requirements
- R1: In the clock after a request is taken, the cycle is in T1. For exactly that one clock, `adr_latch` is 1, `bus_out` drives address bits 15:0 with `bus_oe`=1, and `ust_out` drives address bits 19:16 with `ust_oe`=1. A request presented in T4 starts the next T1 with no idle clock between.
- R2: From T2 through T4, a read leaves `bus_oe`=0. A write drives `bus_oe`=1 with the write data on `bus_out`.
- R3: `wr_strb_n` (active low) is 0 in T2, T3 and every wait state of a write. `rd_strb_n` (active low) is 0 in T3 and every wait state of a read, one state later than the write strobe. The two strobes are never low together, and both are high in T1 and T4.
- R4: `mem_sel` is 1 for memory and 0 for I/O. `dir_tx` is 1 for a write (transmit) and 0 for a read (receive). Both stay constant from T1 through T4.
- R5: `dat_en_n` (active low) is 0 from T2 through T4 and 1 in T1 and idle.
- R6: While `rdy` is 0 at the end of T3 or of a wait state, one more wait state follows. T4 follows the first such state that ends with `rdy`=1. In T4 `done` is 1 for one clock. For a read, `rdata` then equals the `bus_in` value at the end of that last state.
- R7: In T1, `hi_byte_n` equals the inverse of the request's high-byte flag, and `bus_out` bit 0 is address bit 0. Together they select low byte, high byte or both.
- R8: From T2 through T4, `ust_out` carries status: bit 3 is 0, bit 2 is the request's interrupt-enable flag, and bits 1:0 are the segment code (00 extra, 01 stack, 10 code/none, 11 data). `hi_byte_n` carries status 0 in these states.
- R9: A hold request seen in IDLE or T4 raises `hold_ack` in the next clock, ahead of any pending request. A hold request seen during T1 to TW does not interrupt the cycle: `hold_ack` rises in the clock after T4. No new cycle starts while holding.
- R10: While `hold_ack` is 1, `bus_oe`, `ust_oe`, `hi_byte_oe` and `ctl_oe` are all 0.
- R11: When `hold_req` drops during a hold, `hold_ack` drops in the next clock.
- R12: With no request and no hold, the sequencer stays idle: `adr_latch`=0, all strobes and `dat_en_n` high, and `bus_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_hi | input | 1 | High byte wanted |
| req_seg | input | 2 | Segment code reported as status |
| req_ie | input | 1 | Interrupt-enable flag reported as status |
| req_take | output | 1 | Request accepted this clock |
| done | output | 1 | Cycle in T4 |
| rdata | output | 16 | Captured read data |
| adr_latch | output | 1 | Address latch strobe |
| bus_out | output | 16 | Shared address/data value |
| bus_oe | output | 1 | Shared lines output enable |
| bus_in | input | 16 | Shared lines as seen from outside |
| ust_out | output | 4 | Upper address / status value |
| ust_oe | output | 1 | Upper lines output enable |
| hi_byte_n | output | 1 | High-byte enable, active low / status |
| hi_byte_oe | output | 1 | High-byte pin output enable |
| mem_sel | output | 1 | Memory (1) or I/O (0) |
| dir_tx | output | 1 | Transmit (1) or receive (0) |
| rd_strb_n | output | 1 | Read strobe, active low |
| wr_strb_n | output | 1 | Write strobe, active low |
| dat_en_n | output | 1 | Data enable, active low |
| ctl_oe | output | 1 | Control pins output enable |
| rdy | input | 1 | Slave ready; low inserts wait states |
| hold_req | input | 1 | External master requests the bus |
| hold_ack | output | 1 | Bus granted away |

## Verification
The checker watches, on every clock, the properties that hold locally in time. The latch strobe lasts a single clock. The read and write strobes never overlap. Every bus and control enable is off while the bus is held. The select and direction pins stay stable while data is enabled. `done` follows a ready clock. A hold release drops the grant on the next clock. The bench scenarios cover the points that depend on request contents and ordering. These are the exact address, data and status values on the shared lines, the number of inserted waits, the data captured for reads, back-to-back cycles, and the deferral of a hold that arrives mid-cycle until after T4.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_T1   = 3'd1,
        S_T2   = 3'd2,
        S_T3   = 3'd3,
        S_TW   = 3'd4,
        S_T4   = 3'd5,
        S_HOLD = 3'd6
    } bstate_e;

    // mode bits carried with a transfer for its whole life
    typedef struct packed {
        logic       write;
        logic       mem;
        logic       hi;
        logic [1:0] seg;
        logic       ie;
    } bmode_t;

endpackage

// File: rtl/bseq_fsm.sv
module bseq_fsm
    import bseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    hold_req,
    input  logic    rdy,
    output bstate_e state,
    output logic    take
);

    bstate_e nxt;

    // a cycle may start only at a cycle boundary, and hold wins over it
    assign take = ((state == S_IDLE) || (state == S_T4)) && req_valid && !hold_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE, S_T4: begin
                if (hold_req)       nxt = S_HOLD;
                else if (req_valid) nxt = S_T1;
                else                nxt = S_IDLE;
            end
            S_T1:   nxt = S_T2;
            S_T2:   nxt = S_T3;
            S_T3, S_TW: nxt = rdy ? S_T4 : S_TW;
            S_HOLD: nxt = hold_req ? S_HOLD : S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

endmodule

// File: rtl/bseq_req.sv
module bseq_req
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bstate_e           state,
    input  logic              take,
    input  bmode_t            mode_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              rdy,
    input  logic [DATA_W-1:0] bus_in,
    output bmode_t            mode_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    logic last_data_state;

    // T3 or a wait state that ends with ready: the data phase closes here
    assign last_data_state = ((state == S_T3) || (state == S_TW)) && rdy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '{write: 1'b0, mem: 1'b1, hi: 1'b0, seg: 2'b10, ie: 1'b0};
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (take) begin
            mode_q  <= mode_in;
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               rdata_q <= '0;
        else if (last_data_state && !mode_q.write) rdata_q <= bus_in;
    end

endmodule

// File: rtl/bseq_pads.sv
module bseq_pads
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  bstate_e                  state,
    input  bmode_t                   mode_q,
    input  logic [ADDR_W-1:0]        addr_q,
    input  logic [DATA_W-1:0]        wdata_q,
    output logic                     adr_latch,
    output logic [DATA_W-1:0]        bus_out,
    output logic                     bus_oe,
    output logic [ADDR_W-DATA_W-1:0] ust_out,
    output logic                     ust_oe,
    output logic                     hi_byte_n,
    output logic                     hi_byte_oe,
    output logic                     mem_sel,
    output logic                     dir_tx,
    output logic                     rd_strb_n,
    output logic                     wr_strb_n,
    output logic                     dat_en_n,
    output logic                     ctl_oe
);

    localparam int UP_W = ADDR_W - DATA_W;

    logic [UP_W-1:0] status;

    // status word: seg in bits 1:0, interrupt flag in bit 2, rest zero
    always_comb begin
        status    = '0;
        status[1:0] = mode_q.seg;
        status[2]   = mode_q.ie;
    end

    always_comb begin
        adr_latch  = 1'b0;
        bus_out    = wdata_q;
        bus_oe     = 1'b0;
        ust_out    = status;
        ust_oe     = 1'b0;
        hi_byte_n  = 1'b1;
        hi_byte_oe = 1'b0;
        mem_sel    = mode_q.mem;
        dir_tx     = mode_q.write;
        rd_strb_n  = 1'b1;
        wr_strb_n  = 1'b1;
        dat_en_n   = 1'b1;
        ctl_oe     = 1'b1;
        unique case (state)
            S_IDLE: begin
            end
            S_T1: begin
                adr_latch  = 1'b1;
                bus_out    = addr_q[DATA_W-1:0];
                bus_oe     = 1'b1;
                ust_out    = addr_q[ADDR_W-1:DATA_W];
                ust_oe     = 1'b1;
                hi_byte_n  = ~mode_q.hi;
                hi_byte_oe = 1'b1;
            end
            S_T2: begin
                bus_oe     = mode_q.write;
                ust_oe     = 1'b1;
                hi_byte_n  = 1'b0;
                hi_byte_oe = 1'b1;
                wr_strb_n  = ~mode_q.write;
                dat_en_n   = 1'b0;
            end
            S_T3, S_TW: begin
                bus_oe     = mode_q.write;
                ust_oe     = 1'b1;
                hi_byte_n  = 1'b0;
                hi_byte_oe = 1'b1;
                wr_strb_n  = ~mode_q.write;
                rd_strb_n  = mode_q.write;
                dat_en_n   = 1'b0;
            end
            S_T4: begin
                bus_oe     = mode_q.write;
                ust_oe     = 1'b1;
                hi_byte_n  = 1'b0;
                hi_byte_oe = 1'b1;
                dat_en_n   = 1'b0;
            end
            S_HOLD: begin
                ctl_oe     = 1'b0;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/bseq_top.sv
module bseq_top
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int UP_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_hi,
    input  logic [1:0]        req_seg,
    input  logic              req_ie,
    output logic              req_take,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              adr_latch,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] bus_in,
    output logic [UP_W-1:0]   ust_out,
    output logic              ust_oe,
    output logic              hi_byte_n,
    output logic              hi_byte_oe,
    output logic              mem_sel,
    output logic              dir_tx,
    output logic              rd_strb_n,
    output logic              wr_strb_n,
    output logic              dat_en_n,
    output logic              ctl_oe,
    input  logic              rdy,
    input  logic              hold_req,
    output logic              hold_ack
);

    bstate_e           state;
    bmode_t            mode_in;
    bmode_t            mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    assign mode_in = '{write: req_write, mem: req_mem, hi: req_hi, seg: req_seg, ie: req_ie};

    bseq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .hold_req  (hold_req),
        .rdy       (rdy),
        .state     (state),
        .take      (req_take)
    );

    bseq_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .take     (req_take),
        .mode_in  (mode_in),
        .addr_in  (req_addr),
        .wdata_in (req_wdata),
        .rdy      (rdy),
        .bus_in   (bus_in),
        .mode_q   (mode_q),
        .addr_q   (addr_q),
        .wdata_q  (wdata_q),
        .rdata_q  (rdata)
    );

    bseq_pads #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pads (
        .state      (state),
        .mode_q     (mode_q),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q),
        .adr_latch  (adr_latch),
        .bus_out    (bus_out),
        .bus_oe     (bus_oe),
        .ust_out    (ust_out),
        .ust_oe     (ust_oe),
        .hi_byte_n  (hi_byte_n),
        .hi_byte_oe (hi_byte_oe),
        .mem_sel    (mem_sel),
        .dir_tx     (dir_tx),
        .rd_strb_n  (rd_strb_n),
        .wr_strb_n  (wr_strb_n),
        .dat_en_n   (dat_en_n),
        .ctl_oe     (ctl_oe)
    );

    assign done     = (state == S_T4);
    assign hold_ack = (state == S_HOLD);

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk (
    input logic clk,
    input logic rst_n,
    input logic adr_latch,
    input logic bus_oe,
    input logic ust_oe,
    input logic hi_byte_oe,
    input logic ctl_oe,
    input logic mem_sel,
    input logic dir_tx,
    input logic rd_strb_n,
    input logic wr_strb_n,
    input logic dat_en_n,
    input logic done,
    input logic rdy,
    input logic hold_req,
    input logic hold_ack
);

    // R1: the latch strobe is a single-clock pulse with the address driven
    a_r1_latch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        adr_latch |=> !adr_latch);
    a_r1_latch_drives: assert property (@(posedge clk) disable iff (!rst_n)
        adr_latch |-> (bus_oe && ust_oe));

    // R2: write strobe only while write data is on the lines
    a_r2_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_strb_n |-> bus_oe);

    // R3: strobes never overlap
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_strb_n && !wr_strb_n));

    // R4: select and direction hold steady inside the data phase
    a_r4_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!dat_en_n && $past(!dat_en_n)) |-> ($stable(mem_sel) && $stable(dir_tx)));

    // R5: data enable follows the address phase
    a_r5_den_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
        adr_latch |=> !dat_en_n);

    // R6: completion only after a ready clock
    a_r6_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rdy));

    // R9: grant only answers a request
    a_r9_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> $past(hold_req));

    // R10: everything floats while held
    a_r10_float: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (!bus_oe && !ust_oe && !hi_byte_oe && !ctl_oe));

    // R11: release on the next clock
    a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack && !hold_req) |=> !hold_ack);

endmodule

bind bseq_top bseq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adr_latch  (adr_latch),
    .bus_oe     (bus_oe),
    .ust_oe     (ust_oe),
    .hi_byte_oe (hi_byte_oe),
    .ctl_oe     (ctl_oe),
    .mem_sel    (mem_sel),
    .dir_tx     (dir_tx),
    .rd_strb_n  (rd_strb_n),
    .wr_strb_n  (wr_strb_n),
    .dat_en_n   (dat_en_n),
    .done       (done),
    .rdy        (rdy),
    .hold_req   (hold_req),
    .hold_ack   (hold_ack)
);

// File: tb/bseq_top_tb.sv
module bseq_top_tb;

    typedef struct packed {
        logic        wr;
        logic        mem;
        logic [19:0] addr;
        logic [15:0] wd;
        logic        hi;
        logic [1:0]  seg;
        logic        ie;
        logic [2:0]  waits;
        logic [15:0] rd;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 20'hA1234, 16'h0000, 1'b1, 2'b10, 1'b1, 3'd0, 16'hBEEF},
        '{1'b1, 1'b1, 20'h5F00E, 16'hC3A5, 1'b0, 2'b11, 1'b0, 3'd0, 16'h0000},
        '{1'b0, 1'b0, 20'h00381, 16'h0000, 1'b0, 2'b00, 1'b0, 3'd2, 16'h7E11},
        '{1'b1, 1'b0, 20'h0FFF2, 16'h1357, 1'b1, 2'b01, 1'b1, 3'd1, 16'h0000},
        '{1'b0, 1'b1, 20'hFFFFF, 16'h0000, 1'b1, 2'b11, 1'b1, 3'd3, 16'h8001},
        '{1'b1, 1'b1, 20'h80000, 16'hFFFF, 1'b1, 2'b10, 1'b0, 3'd4, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_hi = 1'b0, req_ie = 1'b0;
    logic [1:0]  req_seg = '0;
    logic [15:0] bus_in = '0;
    logic        rdy = 1'b1, hold_req = 1'b0;
    logic        req_take, done, adr_latch, bus_oe, ust_oe, hi_byte_n, hi_byte_oe;
    logic        mem_sel, dir_tx, rd_strb_n, wr_strb_n, dat_en_n, ctl_oe, hold_ack;
    logic [15:0] rdata, bus_out;
    logic [3:0]  ust_out;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bseq_top u_dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_req(input vec_t v);
        req_valid = 1'b1; req_write = v.wr; req_mem = v.mem; req_addr = v.addr;
        req_wdata = v.wd; req_hi = v.hi; req_seg = v.seg; req_ie = v.ie; bus_in = v.rd;
    endtask

    task automatic run_txn(input vec_t v);
        drive_req(v);
        @(negedge clk); // T1
        chk(adr_latch == 1'b1, "R1 latch in T1", adr_latch, 1);
        chk(bus_oe && bus_out == v.addr[15:0], "R1 low address", bus_out, v.addr[15:0]);
        chk(ust_oe && ust_out == v.addr[19:16], "R1 upper address", ust_out, v.addr[19:16]);
        chk(hi_byte_n == !v.hi && bus_out[0] == v.addr[0], "R7 byte select", hi_byte_n, !v.hi);
        chk(mem_sel == v.mem && dir_tx == v.wr, "R4 select in T1", {mem_sel, dir_tx}, {v.mem, v.wr});
        chk(dat_en_n && rd_strb_n && wr_strb_n, "R5 R3 idle strobes in T1",
            {dat_en_n, rd_strb_n, wr_strb_n}, 3'b111);
        req_valid = 1'b0;
        rdy = (v.waits == 0);
        @(negedge clk); // T2
        chk(!adr_latch, "R1 latch low in T2", adr_latch, 0);
        chk(bus_oe == v.wr, "R2 bus drive in T2", bus_oe, v.wr);
        if (v.wr) chk(bus_out == v.wd, "R2 write data", bus_out, v.wd);
        chk(ust_out == {1'b0, v.ie, v.seg}, "R8 status", ust_out, {1'b0, v.ie, v.seg});
        chk(hi_byte_n == 1'b0, "R8 high-byte status", hi_byte_n, 0);
        chk(wr_strb_n == !v.wr && rd_strb_n, "R3 strobes in T2", {rd_strb_n, wr_strb_n}, {1'b1, !v.wr});
        chk(!dat_en_n, "R5 data enable in T2", dat_en_n, 0);
        @(negedge clk); // T3
        chk(wr_strb_n == !v.wr && rd_strb_n == v.wr, "R3 strobes in T3",
            {rd_strb_n, wr_strb_n}, {v.wr, !v.wr});
        chk(mem_sel == v.mem && dir_tx == v.wr, "R4 select in T3", {mem_sel, dir_tx}, {v.mem, v.wr});
        for (int i = 0; i < int'(v.waits); i++) begin
            @(negedge clk); // TW
            rdy = (i == int'(v.waits) - 1);
            chk(!done, "R6 wait state inserted", done, 0);
            chk(wr_strb_n == !v.wr && rd_strb_n == v.wr, "R3 strobes in wait",
                {rd_strb_n, wr_strb_n}, {v.wr, !v.wr});
        end
        @(negedge clk); // T4
        chk(done, "R6 done in T4", done, 1);
        if (!v.wr) chk(rdata == v.rd, "R6 read data", rdata, v.rd);
        chk(rd_strb_n && wr_strb_n, "R3 strobes off in T4", {rd_strb_n, wr_strb_n}, 2'b11);
        chk(!dat_en_n, "R5 data enable in T4", dat_en_n, 0);
        chk(bus_oe == v.wr, "R2 bus drive in T4", bus_oe, v.wr);
        chk(mem_sel == v.mem && dir_tx == v.wr, "R4 select in T4", {mem_sel, dir_tx}, {v.mem, v.wr});
        rdy = 1'b1;
        @(negedge clk); // idle
        chk(!adr_latch && rd_strb_n && wr_strb_n && dat_en_n && !bus_oe, "R12 idle after cycle",
            {adr_latch, rd_strb_n, wr_strb_n, dat_en_n, bus_oe}, 5'b01110);
    endtask

    task automatic drain(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!hold_ack && !adr_latch && rd_strb_n && wr_strb_n && dat_en_n && !bus_oe,
            "R12 reset state", {hold_ack, adr_latch, bus_oe}, 0);
        rst_n = 1'b1;
        drain(3);
        chk(!adr_latch && rd_strb_n && wr_strb_n && dat_en_n && !bus_oe, "R12 stays idle",
            {adr_latch, dat_en_n}, 2'b01);

        for (int k = 0; k < NVEC; k++) run_txn(VECS[k]);

        // back-to-back: second request presented in T4
        drive_req(VECS[1]);
        @(negedge clk); req_valid = 1'b0; rdy = 1'b1;
        drain(2);
        @(negedge clk); // T4
        drive_req(VECS[0]);
        @(negedge clk);
        chk(adr_latch && bus_out == VECS[0].addr[15:0], "R1 back-to-back T1", bus_out, VECS[0].addr[15:0]);
        req_valid = 1'b0;
        drain(4);

        // hold in idle with a pending request
        hold_req = 1'b1;
        drive_req(VECS[2]);
        @(negedge clk);
        chk(hold_ack && !adr_latch, "R9 hold wins in idle", {hold_ack, adr_latch}, 2'b10);
        chk(!bus_oe && !ust_oe && !hi_byte_oe && !ctl_oe, "R10 floated",
            {bus_oe, ust_oe, hi_byte_oe, ctl_oe}, 0);
        drain(2);
        chk(hold_ack && !adr_latch, "R9 no cycle while holding", {hold_ack, adr_latch}, 2'b10);
        hold_req = 1'b0;
        @(negedge clk);
        chk(!hold_ack && !adr_latch, "R11 release next clock", {hold_ack, adr_latch}, 0);
        @(negedge clk);
        chk(adr_latch, "R9 pending request resumes", adr_latch, 1);
        req_valid = 1'b0; rdy = 1'b1;
        drain(5);

        // hold arriving mid-cycle waits for T4
        drive_req(VECS[1]);
        @(negedge clk); req_valid = 1'b0; rdy = 1'b1; // T1
        @(negedge clk); hold_req = 1'b1;               // T2
        @(negedge clk);                                 // T3
        chk(!hold_ack && !dat_en_n, "R9 cycle not broken", {hold_ack, dat_en_n}, 0);
        @(negedge clk);                                 // T4
        chk(!hold_ack && done, "R9 cycle completes", {hold_ack, done}, 2'b01);
        @(negedge clk);
        chk(hold_ack, "R9 ack after T4", hold_ack, 1);
        chk(!bus_oe && !ctl_oe, "R10 floated after cycle", {bus_oe, ctl_oe}, 0);
        hold_req = 1'b0;
        @(negedge clk);
        chk(!hold_ack, "R11 ack drops", hold_ack, 0);
        drain(2);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule